// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block converts a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. It runs in one of two modes. The mode is held in a one-bit register that loads from bit 0 of a control word. In real mode the selector is multiplied by sixteen and added to the offset. In protected mode the base of a descriptor, which the caller has already fetched and presents on the ports, is added to the offset. Before the result is accepted, the offset is compared against the descriptor's segment limit.

A caller raises `reqValid` for one cycle with all operands stable. On the next clock edge the block reports either a valid address or a limit fault. The limit is a 20-bit count. A granularity flag decides whether that count is in bytes or in 4 KB pages. Descriptor fetch, privilege checks and paging are handled elsewhere.

Top module: `seg_lin_addr_gen`

## Requirements
- R1: After reset `outValid`, `limitFault` and `linAddr` are all 0, and the block is in real mode.
- R2: When `ctlWrEn` is high at a clock edge, the mode register loads `ctlWrData[0]` (1 = protected, 0 = real). Bits 31..1 of `ctlWrData` have no effect. The new mode applies to requests from the next cycle on.
- R3: In real mode the result is ((selector << 4) + offset) truncated to 20 bits and zero-extended, so `linAddr[31:20]` is always 0.
- R4: In protected mode the result is (descBase + offset) mod 2^32. The selector has no effect.
- R5: In protected mode with `descGran` = 0, the byte limit is `descLimit` zero-extended. An offset equal to the limit is accepted, and an offset one above it faults.
- R6: In protected mode with `descGran` = 1, the byte limit is {descLimit, 12'hFFF}.
- R7: When a request faults, the next cycle has `limitFault` = 1, `outValid` = 0 and `linAddr` = 0. The two flags are never high together.
- R8: Results appear exactly one cycle after `reqValid`. A cycle with no request gives `outValid` = 0, `limitFault` = 0 and `linAddr` = 0 on the next cycle.
- R9: In real mode the descriptor inputs are ignored and no limit fault is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Load the mode register from the control word |
| ctlWrData | input | 32 | Control word; only bit 0 (protected enable) is used |
| reqValid | input | 1 | Translation request strobe |
| selector | input | 16 | Segment selector value |
| offset | input | 32 | Offset within the segment |
| descBase | input | 32 | Cached descriptor base |
| descLimit | input | 20 | Cached descriptor limit |
| descGran | input | 1 | Granularity: 0 = bytes, 1 = 4 KB units |
| outValid | output | 1 | Linear address valid this cycle |
| linAddr | output | 32 | Linear address (0 when not valid) |
| limitFault | output | 1 | Offset exceeded the segment limit |

## Verification
A stale or corrupted mode bit shows up on the very next result. Real-mode results would carry a nonzero top twelve bits, or protected-mode results would ignore the base. A mis-scaled limit shows only at the boundary offsets: exactly at the limit, one past it, and the last byte of a 4 KB page. For that reason the vectors sit on those edges. Because the block has a single register stage, any fault in the output registers appears one cycle after the request that exposes it.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;
  localparam int unsigned SEL_W    = 16;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned LIM_W    = 20;
  localparam int unsigned REAL_SH  = 4;
  localparam int unsigned PAGE_SH  = ADDR_W - LIM_W;
  localparam int unsigned REAL_W   = LIM_W;

  typedef struct packed {
    logic capture;
    logic fault;
    logic useProt;
  } agenStrobe_t;
endpackage

// File: rtl/seg_agen_ctrl.sv
module seg_agen_ctrl
  import seg_agen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWrEn,
  input  logic        ctlProtBit,
  input  logic        reqValid,
  input  logic        overLimit,
  output agenStrobe_t strb
);
  logic protMode;

  always_ff @(posedge clk) begin
    if (!rstN) protMode <= 1'b0;
    else if (ctlWrEn) protMode <= ctlProtBit;
  end

  always_comb begin
    strb.useProt = protMode;
    strb.fault   = reqValid && protMode && overLimit;
    strb.capture = reqValid && !(protMode && overLimit);
  end

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> protMode == $past(ctlProtBit));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrEn |=> $stable(protMode));
endmodule

// File: rtl/seg_agen_dp.sv
module seg_agen_dp
  import seg_agen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  agenStrobe_t       strb,
  input  logic [SEL_W-1:0]  selector,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [LIM_W-1:0]  descLimit,
  input  logic              descGran,
  output logic              overLimit,
  output logic              outValid,
  output logic [ADDR_W-1:0] linAddr,
  output logic              limitFault
);
  logic [ADDR_W-1:0] effLimit;
  logic [REAL_W-1:0] realSum;
  logic [ADDR_W-1:0] protSum;
  logic [ADDR_W-1:0] nextAddr;
  logic              resultProt;

  generate
    if (PAGE_SH > 0) begin : g_scale
      always_comb begin
        if (descGran) effLimit = {descLimit, {PAGE_SH{1'b1}}};
        else          effLimit = {{PAGE_SH{1'b0}}, descLimit};
      end
    end else begin : g_noscale
      always_comb effLimit = ADDR_W'(descLimit);
    end
  endgenerate

  always_comb begin
    overLimit = offset > effLimit;
    realSum   = REAL_W'({selector, {REAL_SH{1'b0}}}) + offset[REAL_W-1:0];
    protSum   = descBase + offset;
    nextAddr  = strb.useProt ? protSum : ADDR_W'(realSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      limitFault <= 1'b0;
      linAddr    <= '0;
      resultProt <= 1'b0;
    end else begin
      outValid   <= strb.capture;
      limitFault <= strb.fault;
      linAddr    <= strb.capture ? nextAddr : '0;
      resultProt <= strb.useProt;
    end
  end

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && limitFault));

  assert_real_top_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !resultProt) |-> linAddr[ADDR_W-1:REAL_W] == '0);

  assert_real_no_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    limitFault |-> resultProt);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> linAddr == '0);
endmodule

// File: rtl/seg_lin_addr_gen.sv
module seg_lin_addr_gen
  import seg_agen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWrEn,
  input  logic [31:0] ctlWrData,
  input  logic        reqValid,
  input  logic [15:0] selector,
  input  logic [31:0] offset,
  input  logic [31:0] descBase,
  input  logic [19:0] descLimit,
  input  logic        descGran,
  output logic        outValid,
  output logic [31:0] linAddr,
  output logic        limitFault
);
  agenStrobe_t strb;
  logic        overLimit;

  seg_agen_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlProtBit(ctlWrData[0]),
    .reqValid(reqValid), .overLimit(overLimit), .strb(strb)
  );

  seg_agen_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .selector(selector), .offset(offset),
    .descBase(descBase), .descLimit(descLimit), .descGran(descGran),
    .overLimit(overLimit), .outValid(outValid), .linAddr(linAddr),
    .limitFault(limitFault)
  );
endmodule

// File: tb/seg_lin_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_lin_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic        reqValid = 1'b0;
  logic [15:0] selector = '0;
  logic [31:0] offset = '0;
  logic [31:0] descBase = '0;
  logic [19:0] descLimit = '0;
  logic        descGran = 1'b0;
  logic        outValid;
  logic [31:0] linAddr;
  logic        limitFault;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  seg_lin_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .reqValid(reqValid), .selector(selector), .offset(offset),
    .descBase(descBase), .descLimit(descLimit), .descGran(descGran),
    .outValid(outValid), .linAddr(linAddr), .limitFault(limitFault)
  );

  // prot, sel, off, base, lim, gran, expValid, expFault, expAddr
  localparam int NV = 10;
  localparam logic [135:0] VEC [NV] = '{
    {1'b0, 16'h1234, 32'h0000_0005, 32'h0,         20'h0,     1'b0, 1'b1, 1'b0, 32'h0001_2345}, // R3
    {1'b0, 16'hFFFF, 32'h0000_0010, 32'h0,         20'h0,     1'b0, 1'b1, 1'b0, 32'h0000_0000}, // R3 wrap
    {1'b0, 16'h0001, 32'hABCD_0000, 32'hDEAD_BEEF, 20'h0,     1'b0, 1'b1, 1'b0, 32'h000D_0010}, // R9
    {1'b1, 16'h0000, 32'h0000_0FFF, 32'h0010_0000, 20'h00FFF, 1'b0, 1'b1, 1'b0, 32'h0010_0FFF}, // R5 edge
    {1'b1, 16'h0000, 32'h0000_1000, 32'h0010_0000, 20'h00FFF, 1'b0, 1'b0, 1'b1, 32'h0},         // R5 over
    {1'b1, 16'h0000, 32'h0000_1FFF, 32'h8000_0000, 20'h00001, 1'b1, 1'b1, 1'b0, 32'h8000_1FFF}, // R6 edge
    {1'b1, 16'h0000, 32'h0000_2000, 32'h8000_0000, 20'h00001, 1'b1, 1'b0, 1'b1, 32'h0},         // R6 over
    {1'b1, 16'h0000, 32'h0000_2000, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 1'b0, 32'h0000_1000}, // R4 wrap
    {1'b1, 16'hFFFF, 32'h0000_0000, 32'h1234_5678, 20'h0,     1'b0, 1'b1, 1'b0, 32'h1234_5678}, // R4 sel ignored
    {1'b1, 16'h0000, 32'h0000_0001, 32'h1234_5678, 20'h0,     1'b0, 1'b0, 1'b1, 32'h0}          // R7
  };

  task automatic check(input string req, input logic v, input logic f, input logic [31:0] a);
    nChecks++;
    if (outValid !== v || limitFault !== f || linAddr !== a) begin
      nFails++;
      $display("FAIL %s: got valid=%0b fault=%0b addr=%08h, expected valid=%0b fault=%0b addr=%08h",
               req, outValid, limitFault, linAddr, v, f, a);
    end
  endtask

  task automatic setMode(input logic [31:0] w);
    @(negedge clk); ctlWrEn = 1'b1; ctlWrData = w;
    @(negedge clk); ctlWrEn = 1'b0; ctlWrData = '0;
  endtask

  task automatic drive(input logic [15:0] s, input logic [31:0] o, input logic [31:0] b,
                       input logic [19:0] l, input logic g);
    @(negedge clk);
    reqValid = 1'b1; selector = s; offset = o; descBase = b; descLimit = l; descGran = g;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", 1'b0, 1'b0, 32'h0);
    // R1: still real mode after reset, descriptor ignored
    drive(16'h0100, 32'h0000_0002, 32'hFFFF_FFFF, 20'h0, 1'b0);
    check("R1 real after reset", 1'b1, 1'b0, 32'h0000_1002);

    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      v = VEC[i];
      setMode({31'h0, v[135]});
      drive(v[134:119], v[118:87], v[86:55], v[54:35], v[34]);
      check($sformatf("R3-R7 vector %0d", i), v[33], v[32], v[31:0]);
      @(negedge clk);
      check("R8 no request", 1'b0, 1'b0, 32'h0);
    end

    // R2: upper bits ignored, bit 0 clear -> real mode
    setMode(32'hFFFF_FFFE);
    drive(16'h0010, 32'h0000_0200, 32'h5000_0000, 20'h0, 1'b0);
    check("R2 upper bits ignored", 1'b1, 1'b0, 32'h0000_0300);
    // R2: bit 0 set with others -> protected
    setMode(32'h8000_0001);
    drive(16'h0010, 32'h0000_0000, 32'h5000_0000, 20'h0, 1'b0);
    check("R2 protected select", 1'b1, 1'b0, 32'h5000_0000);

    // R8: back-to-back requests, each one cycle later
    @(negedge clk);
    reqValid = 1'b1; offset = 32'h10; descBase = 32'h100; descLimit = 20'hFF; descGran = 1'b0;
    @(negedge clk);
    check("R8 back-to-back first", 1'b1, 1'b0, 32'h0000_0110);
    offset = 32'h100;
    @(negedge clk);
    reqValid = 1'b0;
    check("R7 back-to-back fault", 1'b0, 1'b1, 32'h0);
    @(negedge clk);
    check("R8 drop after burst", 1'b0, 1'b0, 32'h0);

    // R1: reset mid-run returns to real mode
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears", 1'b0, 1'b0, 32'h0);
    rstN = 1'b1;
    drive(16'h0000, 32'h0000_5000, 32'h0, 20'h0, 1'b0);
    check("R9 real after re-reset no fault", 1'b1, 1'b0, 32'h0000_5000);

    finishRun();
  end
endmodule